// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block sends one 8-bit PCM word per frame on a serial data line with a separate output-enable, so that a pad or an outside buffer can release the line between words. The transmit bit clock and the transmit frame sync come from outside. A fast system clock oversamples both of them. Each frame sync starts a new transmit cycle. That cycle sends the word held on the parallel input when the cycle starts, which is the result of the previous encode cycle, with the sign bit (MSB) first.

The port supports two frame sync formats. A short sync is about one bit period wide. A long sync is three or more bit periods wide. The port finds the format on its own by measuring the width of each frame sync, and it uses the result from the next frame on. The two formats follow different rules for when the output turns on and off. In the long format, each of these times depends on which of two events comes later. A permit flag from the power controller can hold the port silent.

Top module: `pcm_tx_port`

## Requirements
- R1: While `rst` is high and in the cycle after it, `oe_out` is 0. The port leaves reset in short format.
- R2: In short format, a falling bit-clock edge that finds the frame sync high arms a frame. The next rising edge sets `oe_out` and drives the MSB. The output stays off between the arming edge and that rising edge.
- R3: During a frame, `data_out` changes only after rising bit-clock edges. The word goes out MSB first, one bit per rising edge, 8 bits in all. No bits appear beyond the ones the frame holds.
- R4: In short format, `oe_out` drops on the falling edge after the edge that drove the last bit. This holds even if the frame sync is still high. The output is still on while the last bit is driven.
- R5: The port counts the falling bit-clock edges seen while the frame sync is high. When the sync falls, a count of 3 or more selects long format and a count of 1 or 2 selects short format. The result applies to the frames that follow. The format is evaluated again on every frame sync.
- R6: In long format, the frame starts at the frame sync rising edge. If the bit clock is high at that moment, `oe_out` rises at once with the MSB. Otherwise it rises with the MSB at the next rising bit-clock edge.
- R7: In long format, the remaining seven bits follow on the next seven rising edges. `oe_out` drops at the later of two events: the falling edge after the last bit, and the frame sync going low.
- R8: The word is captured from `word_in` when the frame starts. Changes to `word_in` during the frame have no effect on the bits sent.
- R9: While `permit` is 0, `oe_out` is 0 from the next cycle on. Frame syncs are ignored, and a frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bit clock and frame sync |
| rst | input | 1 | Synchronous active-high reset |
| permit | input | 1 | Transmit permitted by the power controller |
| bclk_in | input | 1 | Transmit bit clock (asynchronous, oversampled) |
| fsync_in | input | 1 | Transmit frame sync (asynchronous, oversampled) |
| word_in | input | 8 | Parallel PCM word from the previous encode cycle |
| data_out | output | 1 | Serial PCM data, MSB first |
| oe_out | output | 1 | Output enable for the serial data line |

## Verification
The bench builds the port with its default parameters: two synchronizer stages, an 8-bit word, and a long-format threshold of three falling edges. It runs the bit clock at sixteen system clocks per period. That ratio lets it place the frame sync at a bit-clock edge, in the middle of the high phase or in the middle of the low phase. With these placements it can reach every ordering of the enable and disable events, and sync widths of one, two, four and ten bit periods. It also sends a long pulse while the port is still in short format, drops the permit flag in the middle of a frame, and changes the word after the frame has started.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT_CLK,
    ST_SHIFT,
    ST_TAIL
  } tx_state_t;
endpackage

// File: rtl/pcm_tx_edge.sv
// Synchronizes one asynchronous input and flags its edges for one clk cycle.
module pcm_tx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
      last <= 1'b0;
    end else begin
      pipe <= STAGES'({pipe, din});
      last <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~last;
  assign fall = ~pipe[STAGES-1] & last;
endmodule

// File: rtl/pcm_tx_fsmode.sv
// Measures frame sync width in falling bit-clock edges and decides the format.
module pcm_tx_fsmode #(
  parameter int LONG_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_lvl,
  input  logic fs_fall,
  input  logic bclk_fall,
  output logic long_mode
);
  localparam int CW = $clog2(LONG_MIN + 1);

  logic [CW-1:0] falls;

  always_ff @(posedge clk) begin
    if (rst) begin
      falls     <= '0;
      long_mode <= 1'b0;
    end else if (fs_fall) begin
      long_mode <= (falls >= CW'(LONG_MIN));
      falls     <= '0;
    end else if (fs_lvl && bclk_fall && falls != CW'(LONG_MIN)) begin
      falls <= falls + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_shifter.sv
// Frame sequencing, word capture and serial shifting for both sync formats.
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              permit,
  input  logic              long_mode,
  input  logic              bclk_lvl,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic [WORD_W-1:0] word,
  output logic              dout,
  output logic              oe
);
  localparam int CW = $clog2(WORD_W + 1);

  tx_state_t         state;
  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     nsent;
  logic              fs_used;
  logic              frame_long;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sh         <= '0;
      nsent      <= '0;
      fs_used    <= 1'b0;
      frame_long <= 1'b0;
      dout       <= 1'b0;
      oe         <= 1'b0;
    end else begin
      if (!fs_lvl) fs_used <= 1'b0;
      if (!permit) begin
        state <= ST_IDLE;
        oe    <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (long_mode && fs_rise) begin
              fs_used    <= 1'b1;
              frame_long <= 1'b1;
              if (bclk_lvl) begin
                dout  <= word[WORD_W-1];
                sh    <= {word[WORD_W-2:0], 1'b0};
                nsent <= CW'(1);
                oe    <= 1'b1;
                state <= ST_SHIFT;
              end else begin
                sh    <= word;
                state <= ST_WAIT_CLK;
              end
            end else if (!long_mode && fs_lvl && bclk_fall && !fs_used) begin
              fs_used    <= 1'b1;
              frame_long <= 1'b0;
              sh         <= word;
              state      <= ST_ARMED;
            end
          end
          ST_ARMED, ST_WAIT_CLK: begin
            if (bclk_rise) begin
              dout  <= sh[WORD_W-1];
              sh    <= {sh[WORD_W-2:0], 1'b0};
              nsent <= CW'(1);
              oe    <= 1'b1;
              state <= ST_SHIFT;
            end
          end
          ST_SHIFT: begin
            if (bclk_rise && nsent != CW'(WORD_W)) begin
              dout  <= sh[WORD_W-1];
              sh    <= {sh[WORD_W-2:0], 1'b0};
              nsent <= nsent + 1'b1;
            end else if (bclk_fall && nsent == CW'(WORD_W)) begin
              if (frame_long && fs_lvl) begin
                state <= ST_TAIL;
              end else begin
                oe    <= 1'b0;
                state <= ST_IDLE;
              end
            end
          end
          ST_TAIL: begin
            if (!fs_lvl) begin
              oe    <= 1'b0;
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8,
  parameter int LONG_MIN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              permit,
  input  logic              bclk_in,
  input  logic              fsync_in,
  input  logic [WORD_W-1:0] word_in,
  output logic              data_out,
  output logic              oe_out
);
  localparam int NSIG = 2;
  localparam int IDX_BCLK = 0;
  localparam int IDX_FS   = 1;

  logic [NSIG-1:0] raw, lvl, rise, fall;
  logic bclk_lvl, bclk_rise, bclk_fall, fs_lvl, fs_rise, fs_fall;
  logic long_mode;

  assign raw[IDX_BCLK] = bclk_in;
  assign raw[IDX_FS]   = fsync_in;

  for (genvar g = 0; g < NSIG; g++) begin : g_in
    pcm_tx_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .lvl  (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  assign bclk_lvl  = lvl[IDX_BCLK];
  assign bclk_rise = rise[IDX_BCLK];
  assign bclk_fall = fall[IDX_BCLK];
  assign fs_lvl    = lvl[IDX_FS];
  assign fs_rise   = rise[IDX_FS];
  assign fs_fall   = fall[IDX_FS];

  pcm_tx_fsmode #(.LONG_MIN(LONG_MIN)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .fs_lvl    (fs_lvl),
    .fs_fall   (fs_fall),
    .bclk_fall (bclk_fall),
    .long_mode (long_mode)
  );

  pcm_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .permit    (permit),
    .long_mode (long_mode),
    .bclk_lvl  (bclk_lvl),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .fs_lvl    (fs_lvl),
    .fs_rise   (fs_rise),
    .word      (word_in),
    .dout      (data_out),
    .oe        (oe_out)
  );
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic clk,
  input logic rst,
  input logic permit,
  input logic oe_out,
  input logic data_out,
  input logic bclk_rise,
  input logic bclk_fall,
  input logic fs_rise,
  input logic fs_lvl
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> !oe_out);

  // R9
  a_r9_permit_gate: assert property (@(posedge clk) disable iff (rst)
    !permit |=> !oe_out);

  // R2 and R6: enable follows a bit-clock or frame sync rising edge
  a_r2_oe_rise_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_out) |-> $past(bclk_rise || fs_rise));

  // R3
  a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    (oe_out && $past(oe_out) && !$past(bclk_rise)) |-> $stable(data_out));

  // R4 and R7: disable follows a falling bit-clock edge, a low sync or a withdrawn permit
  a_r4_oe_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_out) |-> $past(bclk_fall || !fs_lvl || !permit));
endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .permit    (permit),
  .oe_out    (oe_out),
  .data_out  (data_out),
  .bclk_rise (bclk_rise),
  .bclk_fall (bclk_fall),
  .fs_rise   (fs_rise),
  .fs_lvl    (fs_lvl)
);

// File: tb/pcm_tx_port_test.sv
module pcm_tx_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       permit = 1'b1;
  logic       bclk_in = 1'b0;
  logic       fsync_in = 1'b0;
  logic [7:0] word_in = 8'h00;
  logic       data_out, oe_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  oe_seen = 1'b0;
  logic exp_q[$];

  pcm_tx_port uut (
    .clk      (clk),
    .rst      (rst),
    .permit   (permit),
    .bclk_in  (bclk_in),
    .fsync_in (fsync_in),
    .word_in  (word_in),
    .data_out (data_out),
    .oe_out   (oe_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver side of the scoreboard
  task automatic push_word(input logic [7:0] w, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(w[7-i]);
  endtask

  task automatic seg(input logic b, input logic f, input int n);
    @(negedge clk);
    bclk_in  = b;
    fsync_in = f;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic bp(input logic f_hi, input logic f_lo);
    seg(1'b1, f_hi, HALF);
    seg(1'b0, f_lo, HALF);
  endtask

  // monitor side: samples mid-high of each bit-clock period
  initial begin : monitor
    int   hc = 0;
    int   nbits = 0;
    logic bprev = 1'b0;
    logic e;
    forever begin
      @(negedge clk);
      #1;
      if (bclk_in && !bprev) hc = 1;
      else if (bclk_in) hc++;
      else hc = 0;
      bprev = bclk_in;
      if (oe_out) oe_seen = 1'b1;
      if (!oe_out) nbits = 0;
      if (!rst && hc == 6 && oe_out && nbits < 8) begin
        nbits++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected bit on line", int'(data_out), -1);
        end else begin
          e = exp_q.pop_front();
          chk(data_out == e, "R3 serial bit", int'(data_out), int'(e));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    report();
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(oe_out == 1'b0, "R1 oe after reset", int'(oe_out), 0);
    chk(data_out == 1'b0, "R1 data after reset", int'(data_out), 0);
    bp(0, 0); bp(0, 0);

    // Frame 1: short format from reset (R1, R2, R4)
    word_in = 8'hA5; push_word(8'hA5, 8);
    seg(1, 1, HALF);
    seg(0, 1, 5);
    chk(oe_out == 1'b0, "R2 armed but not yet enabled", int'(oe_out), 0);
    seg(0, 1, 3);
    repeat (7) bp(0, 0);
    seg(1, 0, 6);
    chk(oe_out == 1'b1, "R4 enabled during last bit", int'(oe_out), 1);
    seg(1, 0, 2);
    seg(0, 0, 5);
    chk(oe_out == 1'b0, "R4 short disable after last bit", int'(oe_out), 0);
    seg(0, 0, 3);
    bp(0, 0); bp(0, 0);

    // Frame 2: two-period sync stays short (R5)
    word_in = 8'h3C; push_word(8'h3C, 8);
    bp(1, 1); bp(1, 1);
    repeat (7) bp(0, 0);
    bp(0, 0); bp(0, 0);

    // Frame 3: sync rises mid-high; short format must wait (R5)
    word_in = 8'h81; push_word(8'h81, 8);
    seg(1, 0, 2);
    seg(1, 1, 4);
    chk(oe_out == 1'b0, "R5 two-period sync kept short format", int'(oe_out), 0);
    seg(1, 1, 2);
    seg(0, 1, HALF);
    seg(1, 1, 2); seg(1, 0, 6); seg(0, 0, HALF);
    repeat (7) bp(0, 0);
    bp(0, 0); bp(0, 0);

    // Frame 4: ten-period sync, still handled with short rules (R5, R4)
    word_in = 8'h5A; push_word(8'h5A, 8);
    bp(1, 1);
    repeat (7) bp(1, 1);
    seg(1, 1, HALF);
    seg(0, 1, 5);
    chk(oe_out == 1'b0, "R4 short disable ignores high sync", int'(oe_out), 0);
    seg(0, 1, 3);
    bp(1, 1);
    bp(0, 0); bp(0, 0);

    // Frame 5: long format, sync rises with bit clock and outlasts the word (R6, R7)
    word_in = 8'hC3; push_word(8'hC3, 8);
    seg(1, 1, 5);
    chk(oe_out == 1'b1, "R6 long enable at aligned edges", int'(oe_out), 1);
    seg(1, 1, 3);
    seg(0, 1, HALF);
    repeat (7) bp(1, 1);
    seg(1, 1, HALF);
    seg(0, 1, 5);
    chk(oe_out == 1'b1, "R7 long hold while sync high", int'(oe_out), 1);
    seg(0, 1, 3);
    seg(1, 0, 5);
    chk(oe_out == 1'b0, "R7 long disable on sync low", int'(oe_out), 0);
    seg(1, 0, 3);
    seg(0, 0, HALF);
    bp(0, 0);

    // Frame 6: long format, sync rises while bit clock low, ends early (R6, R7)
    word_in = 8'h24; push_word(8'h24, 8);
    seg(1, 0, HALF);
    seg(0, 0, 2);
    seg(0, 1, 4);
    chk(oe_out == 1'b0, "R6 long waits for bit-clock rise", int'(oe_out), 0);
    seg(0, 1, 2);
    repeat (4) bp(1, 1);
    repeat (3) bp(0, 0);
    seg(1, 0, 6);
    chk(oe_out == 1'b1, "R7 long still on after sync low", int'(oe_out), 1);
    seg(1, 0, 2);
    seg(0, 0, 5);
    chk(oe_out == 1'b0, "R7 long disable after last bit", int'(oe_out), 0);
    seg(0, 0, 3);
    bp(0, 0); bp(0, 0);

    // Frame 7: long format, sync rises while bit clock high (R6)
    word_in = 8'h0F; push_word(8'h0F, 8);
    seg(1, 0, 1);
    seg(1, 1, 4);
    chk(oe_out == 1'b1, "R6 long immediate enable on sync rise", int'(oe_out), 1);
    seg(1, 1, 3);
    seg(0, 1, HALF);
    repeat (3) bp(1, 1);
    repeat (4) bp(0, 0);
    bp(0, 0); bp(0, 0);

    // Frame 8: long format, one-period sync; the next frame returns to short (R5)
    word_in = 8'h96; push_word(8'h96, 8);
    bp(1, 1);
    repeat (7) bp(0, 0);
    bp(0, 0); bp(0, 0);

    // Frame 9: short again after re-evaluation (R5)
    word_in = 8'h69; push_word(8'h69, 8);
    seg(1, 0, 2);
    seg(1, 1, 4);
    chk(oe_out == 1'b0, "R5 re-evaluated to short format", int'(oe_out), 0);
    seg(1, 1, 2);
    seg(0, 1, HALF);
    seg(1, 1, 2); seg(1, 0, 6); seg(0, 0, HALF);
    repeat (7) bp(0, 0);
    bp(0, 0); bp(0, 0);

    // Frame 10: permit low, frame sync ignored (R9)
    permit = 1'b0;
    oe_seen = 1'b0;
    word_in = 8'hFF;
    bp(1, 1);
    repeat (10) bp(0, 0);
    chk(oe_seen == 1'b0, "R9 no enable while permit low", int'(oe_seen), 0);
    permit = 1'b1;
    bp(0, 0);

    // Frame 11: word captured at frame start (R8)
    word_in = 8'h7E; push_word(8'h7E, 8);
    bp(1, 1);
    word_in = 8'h00;
    repeat (8) bp(0, 0);
    bp(0, 0); bp(0, 0);

    // Frame 12: permit withdrawn mid-frame (R9)
    word_in = 8'hB1; push_word(8'hB1, 3);
    bp(1, 1);
    bp(0, 0); bp(0, 0);
    seg(1, 0, HALF);
    permit = 1'b0;
    seg(0, 0, 4);
    chk(oe_out == 1'b0, "R9 abandon frame on permit low", int'(oe_out), 0);
    seg(0, 0, HALF - 4);
    repeat (6) bp(0, 0);
    permit = 1'b1;
    bp(0, 0); bp(0, 0);

    chk(exp_q.size() == 0, "R3 all expected bits sent", exp_q.size(), 0);
    report();
  end
endmodule